// File: doc/BRIEF.md
# Pipelined Byte-Serial Instruction Fetch Sequencer

This block is the front end of a 32-bit, sixteen-register processor. It pulls 16-bit instructions out of a byte-wide synchronous memory one byte at a time. That memory returns the byte for an address two clock edges after the address register was loaded. The sequencer loads a fresh address on every cycle, so the high and low instruction bytes arrive on consecutive cycles with no idle slot between them.

As soon as the high byte arrives, its top nibble (the opcode) decides where the read address goes next. For a stack pop, the address is reloaded from the stack-pointer value so that the popped long word streams in. For a load-immediate-long or a set-and-branch, the address simply keeps counting so that the bytes trailing the instruction stream in. Every other opcode ends its fetch after two bytes. The block hands the assembled word to decode with a one-cycle strobe, then hands over any trailing bytes one per cycle with their own strobe and index. It keeps the program counter up to date, counting one for every instruction byte it consumes.

While the sequencer sits in its start state it raises a strobe that tells the register file to pin register 0 to zero, register 1 to one and bit 31 of register 13 to one. An external halt input parks it in that state.

Top module: `fetch_seq`

## Requirements
- R1: A synchronous active-low reset sets `pc` and `mem_addr` to 0, clears `instr`, `decode_valid` and `tail_valid`, and returns the sequencer to its start state, so `seed_consts` reads 1.
- R2: `seed_consts` is 1 in every cycle the sequencer is in its start state, and 0 in the cycles after it leaves to fetch.
- R3: While `halted` is 1 in the start state, the sequencer stays there. `pc` holds, `mem_addr` equals `pc`, and no strobe fires. Clearing `halted` resumes fetching at `pc`.
- R4: A new address is driven on every cycle of a fetch. In the three cycles after the sequencer leaves the start state with `pc`=P, `mem_addr` reads P, then P+1, then the next address.
- R5: The byte read from address P becomes `instr[15:8]` and the byte read from P+1 becomes `instr[7:0]`. `decode_valid` is a one-cycle pulse in the cycle `instr` takes the new word. The opcode is `instr[15:12]`.
- R6: `pc` rises by one for each instruction byte consumed and never otherwise changes outside reset. At the `decode_valid` cycle, `pc` = P+2.
- R7: Opcode 4'hA (load immediate long) is followed by four trailing bytes, read from P+2 to P+5. They appear on `tail_byte` with `tail_valid` on four consecutive cycles right after `decode_valid`, with `tail_idx` counting 0 to 3, and `pc` steps to P+6.
- R8: Opcode 4'hD (set and branch) is followed by two trailing bytes, read from P+2 and P+3. They appear with `tail_idx` 0 and 1 right after `decode_valid`, and `pc` ends at P+4.
- R9: For opcode 4'h1 (pop), the address loaded after the high byte arrives is `sp_value`. The four bytes at `sp_value` to `sp_value`+3 are presented as tail bytes 0 to 3, and `pc` stays at P+2.
- R10: Every other opcode has no trailing bytes. The next instruction's `decode_valid` comes exactly 4 cycles after the previous strobe (decode or last tail byte) when `halted` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halted | input | 1 | Hold the sequencer in its start state |
| sp_value | input | 32 | Current stack-pointer register contents |
| mem_addr | output | 32 | Registered byte read address to memory |
| mem_rdata | input | 8 | Memory read data, valid two edges after the address loads |
| pc | output | 32 | Program counter |
| instr | output | 16 | Assembled instruction word |
| decode_valid | output | 1 | One-cycle strobe: `instr` holds a new word |
| tail_byte | output | 8 | Trailing immediate, offset or popped byte |
| tail_valid | output | 1 | One-cycle strobe per trailing byte |
| tail_idx | output | 2 | Index of the trailing byte within its group |
| seed_consts | output | 1 | Start-state strobe for pinning registers 0, 1 and 13 |

## Verification
Counting edges after the sequencer leaves the start state, the address appears one edge later, the high byte is captured at the third edge and the word with `decode_valid` at the fourth. Each trailing byte follows one edge after the one before it. The expected gap to the next decode is 4 cycles. The bench's driver queues each expected word or byte together with that cycle gap and the `pc` value due with it. A monitor samples at the falling edge, pops the queue in order on each strobe, and compares value, index, `pc` and the measured gap. Halt, resume and reset are checked at fixed falling edges after the stimulus that caused them.

// File: rtl/fetch_seq_pkg.sv
// Shared types for the byte-serial fetch sequencer.
// Assumes nothing beyond being compiled ahead of the fetch modules.
package fetch_seq_pkg;

    // Sequencer phases: issue first address, issue second, take high byte,
    // take low byte, take trailing bytes.
    typedef enum logic [2:0] {
        ST_ISSUE = 3'd0,
        ST_PRIME = 3'd1,
        ST_HIGH  = 3'd2,
        ST_LOW   = 3'd3,
        ST_TAIL  = 3'd4
    } fstate_e;

endpackage

// File: rtl/fetch_seq_ctrl.sv
// Phase controller of the fetch sequencer.
// Decides, from the opcode nibble present on the read data in the high-byte
// phase, how many trailing bytes follow and whether they come from the stack.
// Assumes the memory returns data two edges after an address load.
module fetch_seq_ctrl
    import fetch_seq_pkg::*;
#(
    parameter int              OPC_W     = 4,
    parameter logic [OPC_W-1:0] OP_POP   = 4'h1,
    parameter logic [OPC_W-1:0] OP_IMM   = 4'hA,
    parameter logic [OPC_W-1:0] OP_BRA   = 4'hD,
    parameter int              POP_BYTES = 4,
    parameter int              IMM_BYTES = 4,
    parameter int              BRA_BYTES = 2,
    parameter int              TAIL_MAX  = 4,
    localparam int             IDX_W     = $clog2(TAIL_MAX),
    localparam int             CNT_W     = $clog2(TAIL_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halted,
    input  logic [OPC_W-1:0] opcode,
    output logic             at_issue,
    output logic             ld_pc,
    output logic             ld_sp,
    output logic             cap_hi,
    output logic             cap_lo,
    output logic             cap_tail,
    output logic             pc_step,
    output logic [IDX_W-1:0] tail_k
);

    fstate_e          state;
    logic [CNT_W-1:0] tail_n;
    logic [CNT_W-1:0] len_now;
    logic             from_stack;

    // Trailing-byte count implied by the opcode arriving in the high phase.
    always_comb begin
        if (opcode == OP_POP)      len_now = CNT_W'(POP_BYTES);
        else if (opcode == OP_IMM) len_now = CNT_W'(IMM_BYTES);
        else if (opcode == OP_BRA) len_now = CNT_W'(BRA_BYTES);
        else                       len_now = '0;
    end

    // Per-phase strobes steering the address, PC and capture registers.
    always_comb begin
        at_issue = (state == ST_ISSUE);
        ld_pc    = (state == ST_ISSUE);
        ld_sp    = (state == ST_HIGH) && (opcode == OP_POP);
        cap_hi   = (state == ST_HIGH);
        cap_lo   = (state == ST_LOW);
        cap_tail = (state == ST_TAIL);
        pc_step  = (state == ST_HIGH) || (state == ST_LOW) ||
                   ((state == ST_TAIL) && !from_stack);
    end

    // Phase register, trailing-byte count and index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_ISSUE;
            tail_n     <= '0;
            tail_k     <= '0;
            from_stack <= 1'b0;
        end else begin
            case (state)
                ST_ISSUE: if (!halted) state <= ST_PRIME;
                ST_PRIME: state <= ST_HIGH;
                ST_HIGH: begin
                    tail_n     <= len_now;
                    from_stack <= (opcode == OP_POP);
                    state      <= ST_LOW;
                end
                ST_LOW: begin
                    tail_k <= '0;
                    state  <= (tail_n == '0) ? ST_ISSUE : ST_TAIL;
                end
                ST_TAIL: begin
                    tail_k <= tail_k + IDX_W'(1);
                    if (CNT_W'(tail_k) == tail_n - CNT_W'(1)) state <= ST_ISSUE;
                end
                default: state <= ST_ISSUE;
            endcase
        end
    end

endmodule

// File: rtl/fetch_seq_addr.sv
// Read-address register and program counter of the fetch sequencer.
// The address reloads from the PC in the issue phase and from the stack
// pointer on a pop; in every other cycle it counts up by one byte.
module fetch_seq_addr #(
    parameter int               XLEN     = 32,
    parameter logic [XLEN-1:0]  RESET_PC = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_pc,
    input  logic            ld_sp,
    input  logic            pc_step,
    input  logic [XLEN-1:0] sp_value,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] pc
);

    // Streaming byte address: one new address per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)     mem_addr <= RESET_PC;
        else if (ld_pc) mem_addr <= pc;
        else if (ld_sp) mem_addr <= sp_value;
        else            mem_addr <= mem_addr + XLEN'(1);
    end

    // Program counter: one step per instruction byte consumed.
    always_ff @(posedge clk) begin
        if (!rst_n)       pc <= RESET_PC;
        else if (pc_step) pc <= pc + XLEN'(1);
    end

endmodule

// File: rtl/fetch_seq_cap.sv
// Capture registers of the fetch sequencer.
// Holds the high byte until the low byte arrives, then presents the whole
// word with a one-cycle strobe; trailing bytes are presented one per cycle.
module fetch_seq_cap #(
    parameter int BYTE_W = 8,
    parameter int IDX_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BYTE_W-1:0]   rdata,
    input  logic                cap_hi,
    input  logic                cap_lo,
    input  logic                cap_tail,
    input  logic [IDX_W-1:0]    tail_k,
    output logic [2*BYTE_W-1:0] instr,
    output logic                decode_valid,
    output logic [BYTE_W-1:0]   tail_byte,
    output logic                tail_valid,
    output logic [IDX_W-1:0]    tail_idx
);

    logic [BYTE_W-1:0] hi_q;

    // Instruction assembly: high byte first, word released with the low byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q         <= '0;
            instr        <= '0;
            decode_valid <= 1'b0;
        end else begin
            if (cap_hi) hi_q  <= rdata;
            if (cap_lo) instr <= {hi_q, rdata};
            decode_valid <= cap_lo;
        end
    end

    // Trailing-byte presentation in arrival order.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tail_byte  <= '0;
            tail_idx   <= '0;
            tail_valid <= 1'b0;
        end else begin
            if (cap_tail) begin
                tail_byte <= rdata;
                tail_idx  <= tail_k;
            end
            tail_valid <= cap_tail;
        end
    end

endmodule

// File: rtl/fetch_seq.sv
// Byte-serial instruction fetch sequencer (top).
// Streams addresses every cycle into a two-edge-latency byte memory,
// assembles 16-bit instructions, prefetches trailing or popped bytes and
// tracks the program counter. Assumes mem_rdata is registered by the memory.
module fetch_seq #(
    parameter int              XLEN      = 32,
    parameter int              BYTE_W    = 8,
    parameter int              OPC_W     = 4,
    parameter logic [OPC_W-1:0] OP_POP   = 4'h1,
    parameter logic [OPC_W-1:0] OP_IMM   = 4'hA,
    parameter logic [OPC_W-1:0] OP_BRA   = 4'hD,
    parameter int              POP_BYTES = 4,
    parameter int              IMM_BYTES = 4,
    parameter int              BRA_BYTES = 2,
    parameter int              TAIL_MAX  = 4,
    parameter logic [XLEN-1:0] RESET_PC  = '0,
    localparam int             IDX_W     = $clog2(TAIL_MAX)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                halted,
    input  logic [XLEN-1:0]     sp_value,
    output logic [XLEN-1:0]     mem_addr,
    input  logic [BYTE_W-1:0]   mem_rdata,
    output logic [XLEN-1:0]     pc,
    output logic [2*BYTE_W-1:0] instr,
    output logic                decode_valid,
    output logic [BYTE_W-1:0]   tail_byte,
    output logic                tail_valid,
    output logic [IDX_W-1:0]    tail_idx,
    output logic                seed_consts
);

    logic             at_issue;
    logic             ld_pc;
    logic             ld_sp;
    logic             cap_hi;
    logic             cap_lo;
    logic             cap_tail;
    logic             pc_step;
    logic [IDX_W-1:0] tail_k;

    fetch_seq_ctrl #(
        .OPC_W(OPC_W), .OP_POP(OP_POP), .OP_IMM(OP_IMM), .OP_BRA(OP_BRA),
        .POP_BYTES(POP_BYTES), .IMM_BYTES(IMM_BYTES), .BRA_BYTES(BRA_BYTES),
        .TAIL_MAX(TAIL_MAX)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .halted(halted),
        .opcode(mem_rdata[BYTE_W-1 -: OPC_W]),
        .at_issue(at_issue), .ld_pc(ld_pc), .ld_sp(ld_sp),
        .cap_hi(cap_hi), .cap_lo(cap_lo), .cap_tail(cap_tail),
        .pc_step(pc_step), .tail_k(tail_k)
    );

    fetch_seq_addr #(.XLEN(XLEN), .RESET_PC(RESET_PC)) u_addr (
        .clk(clk), .rst_n(rst_n), .ld_pc(ld_pc), .ld_sp(ld_sp),
        .pc_step(pc_step), .sp_value(sp_value),
        .mem_addr(mem_addr), .pc(pc)
    );

    fetch_seq_cap #(.BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .rdata(mem_rdata),
        .cap_hi(cap_hi), .cap_lo(cap_lo), .cap_tail(cap_tail), .tail_k(tail_k),
        .instr(instr), .decode_valid(decode_valid),
        .tail_byte(tail_byte), .tail_valid(tail_valid), .tail_idx(tail_idx)
    );

    // Register-pinning strobe follows the start phase.
    assign seed_consts = at_issue;

endmodule

// File: rtl/fetch_seq_chk.sv
// Temporal checks on the fetch sequencer's ports, bound to every instance.
module fetch_seq_chk #(
    parameter int               XLEN   = 32,
    parameter int               BYTE_W = 8,
    parameter int               OPC_W  = 4,
    parameter logic [OPC_W-1:0] OP_POP = 4'h1,
    parameter int               IDX_W  = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                halted,
    input logic [XLEN-1:0]     sp_value,
    input logic [XLEN-1:0]     mem_addr,
    input logic [XLEN-1:0]     pc,
    input logic [2*BYTE_W-1:0] instr,
    input logic                decode_valid,
    input logic                tail_valid,
    input logic [IDX_W-1:0]    tail_idx,
    input logic                seed_consts
);

    // A decode strobe lasts one cycle.
    assert_decode_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        decode_valid |=> !decode_valid);

    // PC holds or steps by exactly one.
    assert_pc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pc == $past(pc) || pc == $past(pc) + XLEN'(1)));

    // Halt keeps the start phase and the PC.
    assert_halt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (seed_consts && halted) |=> (seed_consts && $stable(pc)));

    // The first trailing byte comes right after the decode strobe.
    assert_tail_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tail_valid && tail_idx == '0) |-> $past(decode_valid));

    // Decode and trailing strobes never coincide.
    assert_strobe_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(decode_valid && tail_valid));

    // A pop redirects the read address to the stack pointer.
    assert_pop_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (decode_valid && instr[2*BYTE_W-1 -: OPC_W] == OP_POP)
            |-> $past(mem_addr) == $past(sp_value, 2));

endmodule

bind fetch_seq fetch_seq_chk #(
    .XLEN(XLEN), .BYTE_W(BYTE_W), .OPC_W(OPC_W), .OP_POP(OP_POP), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .halted(halted), .sp_value(sp_value),
    .mem_addr(mem_addr), .pc(pc), .instr(instr), .decode_valid(decode_valid),
    .tail_valid(tail_valid), .tail_idx(tail_idx), .seed_consts(seed_consts)
);

// File: tb/sim_fetch_seq.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected words and bytes, the monitor
// pops and compares them at the falling edge as the strobes appear.
module sim_fetch_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halted = 1'b1;
    logic [31:0] sp_value = 32'h80;
    logic [31:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic [31:0] pc;
    logic [15:0] instr;
    logic        decode_valid;
    logic [7:0]  tail_byte;
    logic        tail_valid;
    logic [1:0]  tail_idx;
    logic        seed_consts;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int last_evt = 0;

    typedef struct {
        bit          is_tail;
        logic [15:0] val;
        int          idx;
        logic [31:0] pcx;
        int          gap;
        string       req;
    } exp_t;

    exp_t        q[$];
    logic [7:0]  mem [256];

    always #5 clk = ~clk;

    fetch_seq u0 (
        .clk(clk), .rst_n(rst_n), .halted(halted), .sp_value(sp_value),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .pc(pc), .instr(instr),
        .decode_valid(decode_valid), .tail_byte(tail_byte),
        .tail_valid(tail_valid), .tail_idx(tail_idx), .seed_consts(seed_consts)
    );

    // Byte memory with one output register: data two edges after address load.
    always @(posedge clk) mem_rdata <= mem[mem_addr[7:0]];
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: place one instruction and queue what it must produce.
    task automatic put_instr(input int at, input logic [15:0] w, input int gap0, output int nxt);
        int    n;
        int    base;
        bit    pop;
        string rq;
        exp_t  e;
        mem[at]     = w[15:8];
        mem[at + 1] = w[7:0];
        pop  = (w[15:12] == 4'h1);
        n    = (w[15:12] == 4'hA) ? 4 : (w[15:12] == 4'hD) ? 2 : pop ? 4 : 0;
        base = pop ? int'(sp_value) : at + 2;
        rq   = (w[15:12] == 4'hA) ? "R7" : (w[15:12] == 4'hD) ? "R8" : "R9";
        e = '{is_tail: 1'b0, val: w, idx: 0, pcx: 32'(at + 2), gap: gap0, req: "R5"};
        q.push_back(e);
        for (int k = 0; k < n; k++) begin
            e = '{is_tail: 1'b1, val: {8'h00, mem[base + k]}, idx: k,
                  pcx: pop ? 32'(at + 2) : 32'(at + 3 + k), gap: 1, req: rq};
            q.push_back(e);
        end
        nxt = at + 2 + (pop ? 0 : n);
    endtask

    // Monitor: compare each strobe against the queue head.
    always @(negedge clk) begin
        if (rst_n && (decode_valid || tail_valid)) begin
            if (q.size() == 0) begin
                checks++; failures++;
                $display("FAIL R3 actual=unexpected strobe expected=none");
            end else begin
                exp_t e;
                e = q.pop_front();
                chk({e.req, " kind"}, {31'd0, tail_valid}, {31'd0, e.is_tail});
                if (e.is_tail) begin
                    chk({e.req, " byte"}, {24'd0, tail_byte}, {16'd0, e.val});
                    chk({e.req, " idx"}, {30'd0, tail_idx}, 32'(e.idx));
                end else begin
                    chk("R5 instr", {16'd0, instr}, {16'd0, e.val});
                end
                chk("R6 pc", pc, e.pcx);
                if (e.gap != 0) chk("R10 gap", 32'(cyc - last_evt), 32'(e.gap));
            end
            last_evt = cyc;
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int nxt;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        mem[4] = 8'h11; mem[5] = 8'h22; mem[6] = 8'h33; mem[7] = 8'h44;
        mem[10] = 8'hAB; mem[11] = 8'hCD;
        mem[8'h80] = 8'h90; mem[8'h81] = 8'h91; mem[8'h82] = 8'h92; mem[8'h83] = 8'h93;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pc", pc, 32'd0);
        chk("R1 addr", mem_addr, 32'd0);
        chk("R1 strobes", {30'd0, decode_valid, tail_valid}, 32'd0);
        chk("R1 instr", {16'd0, instr}, 32'd0);
        chk("R2 start", {31'd0, seed_consts}, 32'd1);

        put_instr(0, 16'h3210, 0, nxt);
        put_instr(nxt, 16'hA500, 4, nxt);
        put_instr(nxt, 16'hD705, 4, nxt);
        put_instr(nxt, 16'h1E00, 4, nxt);
        put_instr(nxt, 16'h0FFF, 4, nxt);
        put_instr(nxt, 16'hF001, 4, nxt);

        halted = 1'b0;
        @(negedge clk);
        chk("R4 addr0", mem_addr, 32'd0);
        chk("R2 left", {31'd0, seed_consts}, 32'd0);
        @(negedge clk);
        chk("R4 addr1", mem_addr, 32'd1);
        @(negedge clk);
        chk("R4 addr2", mem_addr, 32'd2);

        forever begin
            @(posedge clk); #1;
            if (decode_valid && instr == 16'hF001) break;
        end
        halted = 1'b1;
        repeat (20) @(negedge clk);
        chk("R3 pc", pc, 32'd18);
        chk("R3 addr", mem_addr, 32'd18);
        chk("R3 start", {31'd0, seed_consts}, 32'd1);
        chk("R3 drained", 32'(q.size()), 32'd0);

        put_instr(18, 16'h4C3B, 0, nxt);
        halted = 1'b0;
        forever begin
            @(posedge clk); #1;
            if (decode_valid && instr == 16'h4C3B) break;
        end
        halted = 1'b1;
        repeat (6) @(negedge clk);
        chk("R3 resume pc", pc, 32'd20);
        chk("R3 resume drained", 32'(q.size()), 32'd0);

        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 pc again", pc, 32'd0);
        chk("R1 addr again", mem_addr, 32'd0);
        chk("R1 instr again", {16'd0, instr}, 32'd0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 held pc", pc, 32'd0);
        chk("R2 held start", {31'd0, seed_consts}, 32'd1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule